// File: doc/BRIEF.md
# Link Configuration Snoop Controller

This block sits beside the auxiliary channel of a display link repeater and watches the native write transactions that an upstream source sends to a downstream sink. It owns no registers that software can reach. It picks out the writes to three configuration addresses and keeps a shadow of the link rate and of the lane count. From that shadow it drives a rate-select output, an enable for each of four output lanes, and a low-power standby flag.

The decoding is deliberately lopsided. Exactly one rate code selects the high rate, and every other code falls back to the low rate. An unrecognised lane count turns every lane off until a recognised count arrives. A power-state write of D3 puts the block into standby, and a D0 write brings it back out. While the block is in standby it keeps snooping, so writes made during standby are honoured when it leaves.

Top module: `lcs_top`

## Requirements
- R1: A write to address 0x00100 with data 0x0A drives `rateHigh` to 1. A write of any other data byte to that address, 0x06 included, drives it to 0.
- R2: After reset, `rateHigh` is 0, `laneEn` is 4'b0000 and `standby` is 0.
- R3: A write to address 0x00101 whose bits 4:0 equal 1, 2 or 4 enables lanes from lane 0 upward: `laneEn` becomes 4'b0001, 4'b0011 or 4'b1111 respectively.
- R4: Any other value in bits 4:0 of a write to 0x00101 drives `laneEn` to 4'b0000. It stays there until a write with a valid count arrives.
- R5: Bits 7:5 of the lane-count byte do not affect `laneEn`.
- R6: A write to address 0x00600 whose bits 2:0 are 3'b010 (D3) sets `standby` to 1. Bits 2:0 of 3'b001 (D0) clear it. Any other value leaves it unchanged.
- R7: While `standby` is 1, `laneEn` is 4'b0000 and `rateHigh` still follows the shadowed rate. Writes made during standby update the shadow, and `laneEn` shows the latest shadowed count once standby clears.
- R8: A write to any address other than the three monitored ones changes no output. So does any cycle with `wrValid` low.
- R9: An output reflects a write on the second rising edge after the edge that samples `wrValid`. On the first of those edges the output still holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Decoded native write is present this cycle |
| wrAddr | input | 20 | Address of the write |
| wrData | input | 8 | Data byte of the write |
| rateHigh | output | 1 | 1 selects the high link rate, 0 the low rate |
| laneEn | output | 4 | Output lane enables, bit i for lane i |
| standby | output | 1 | Low-power standby flag |

## Verification
The bench builds the block with its default parameters: a 20-bit address, an 8-bit data byte and four lanes. At that size every byte value written to the rate address and to the lane-count address can be swept one by one. That reaches every invalid lane count and every pattern in the ignored upper bits. All eight power-state codes are applied starting both outside and inside standby. A second pass writes rate and lane counts during standby, so the blanking, the retention of the shadow and the restore on exit can be observed at the ports.

// File: rtl/lcs_pkg.sv
`timescale 1ns/1ps
package lcs_pkg;
  // Strobes from write decode to the shadow datapath
  typedef struct packed {
    logic rateWr;   // write to rate address
    logic laneWr;   // write to lane count address
    logic enterD3;  // power write requesting standby
    logic enterD0;  // power write requesting active
  } snoopStrobe_t;
endpackage

// File: rtl/lcs_ctrl.sv
`timescale 1ns/1ps
module lcs_ctrl
  import lcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 20'h00100,
  parameter logic [ADDR_W-1:0] LANE_ADDR = 20'h00101,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 20'h00600,
  parameter int PWR_FIELD_W = 3,
  parameter logic [PWR_FIELD_W-1:0] D3_CODE = 3'b010,
  parameter logic [PWR_FIELD_W-1:0] D0_CODE = 3'b001
) (
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output snoopStrobe_t      strobe
);
  logic hitRate, hitLane, hitPwr;
  logic [PWR_FIELD_W-1:0] pwrField;

  always_comb begin
    hitRate  = wrValid && (wrAddr == RATE_ADDR);
    hitLane  = wrValid && (wrAddr == LANE_ADDR);
    hitPwr   = wrValid && (wrAddr == PWR_ADDR);
    pwrField = wrData[PWR_FIELD_W-1:0];
    strobe.rateWr  = hitRate;
    strobe.laneWr  = hitLane;
    strobe.enterD3 = hitPwr && (pwrField == D3_CODE);
    strobe.enterD0 = hitPwr && (pwrField == D0_CODE);
  end
endmodule

// File: rtl/lcs_dpath.sv
`timescale 1ns/1ps
module lcs_dpath
  import lcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_LANES = 4,
  parameter int CNT_W = 5,
  parameter logic [DATA_W-1:0] HI_RATE_CODE = 8'h0A
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  snoopStrobe_t         strobe,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 rateHigh,
  output logic [NUM_LANES-1:0] laneEn,
  output logic                 standby
);
  logic             rateShadow;
  logic [CNT_W-1:0] cntShadow;
  logic             stbyState;
  logic             cntValid;
  logic [NUM_LANES-1:0] laneMask;

  // Shadow registers: update on the edge that samples the strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateShadow <= 1'b0;
      cntShadow  <= '0;
      stbyState  <= 1'b0;
    end else begin
      if (strobe.rateWr) rateShadow <= (wrData == HI_RATE_CODE);
      if (strobe.laneWr) cntShadow  <= wrData[CNT_W-1:0];
      if (strobe.enterD3)      stbyState <= 1'b1;
      else if (strobe.enterD0) stbyState <= 1'b0;
    end
  end

  // A count is valid when it is a power of two not above the lane total
  always_comb begin
    cntValid = 1'b0;
    for (int k = 0; (1 << k) <= NUM_LANES; k++) begin
      if (int'(cntShadow) == (1 << k)) cntValid = 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      assign laneMask[i] = cntValid && (int'(cntShadow) > i);
    end
  endgenerate

  // Registered outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateHigh <= 1'b0;
      laneEn   <= '0;
      standby  <= 1'b0;
    end else begin
      rateHigh <= rateShadow;
      laneEn   <= stbyState ? '0 : laneMask;
      standby  <= stbyState;
    end
  end

  // Lanes always form a block starting at lane 0
  p_lane_contig_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((laneEn & (laneEn + 1'b1)) == '0));
  // Standby blanks every lane
  p_standby_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (laneEn == '0));
  // No decoded strobe: shadows hold
  p_no_strobe_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rateWr && !strobe.laneWr) |=> ($stable(rateShadow) && $stable(cntShadow)));
endmodule

// File: rtl/lcs_top.sv
`timescale 1ns/1ps
module lcs_top
  import lcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int NUM_LANES = 4,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 20'h00100,
  parameter logic [ADDR_W-1:0] LANE_ADDR = 20'h00101,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 20'h00600,
  parameter logic [DATA_W-1:0] HI_RATE_CODE = 8'h0A
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 rateHigh,
  output logic [NUM_LANES-1:0] laneEn,
  output logic                 standby
);
  localparam int CNT_W = 5;
  snoopStrobe_t strobe;

  lcs_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .RATE_ADDR(RATE_ADDR), .LANE_ADDR(LANE_ADDR), .PWR_ADDR(PWR_ADDR)
  ) ctrl_i (
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .strobe(strobe)
  );

  lcs_dpath #(
    .DATA_W(DATA_W), .NUM_LANES(NUM_LANES), .CNT_W(CNT_W),
    .HI_RATE_CODE(HI_RATE_CODE)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rateHigh(rateHigh), .laneEn(laneEn), .standby(standby)
  );

  p_rate_decode_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrAddr == RATE_ADDR) |=> ##1 (rateHigh == ($past(wrData, 2) == HI_RATE_CODE)));
  p_d3_enter_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrAddr == PWR_ADDR && wrData[2:0] == 3'b010) |=> ##1 standby);
  p_d0_exit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrAddr == PWR_ADDR && wrData[2:0] == 3'b001) |=> ##1 !standby);
endmodule

// File: tb/lcs_top_tb_top.sv
`timescale 1ns/1ps
module lcs_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic rateHigh;
  logic [3:0] laneEn;
  logic standby;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model
  logic expRate = 1'b0;
  logic [4:0] expCnt = '0;
  logic expStby = 1'b0;

  always #2 clk = ~clk;

  lcs_top dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .rateHigh(rateHigh), .laneEn(laneEn), .standby(standby)
  );

  function automatic logic [3:0] maskOf(logic [4:0] c, logic s);
    logic [3:0] m;
    if (c == 5'd1 || c == 5'd2 || c == 5'd4) m = 4'((32'd1 << c) - 1);
    else m = 4'b0000;
    return s ? 4'b0000 : m;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " rate"}, int'(rateHigh), int'(expRate));
    check({tag, " lanes"}, int'(laneEn), int'(maskOf(expCnt, expStby)));
    check({tag, " standby"}, int'(standby), int'(expStby));
  endtask

  // Drive one write at a negedge; return at the negedge after the output edge
  task automatic doWrite(logic [19:0] a, logic [7:0] d, logic v = 1'b1);
    wrAddr = a; wrData = d; wrValid = v;
    @(negedge clk);
    wrValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic modelWrite(logic [19:0] a, logic [7:0] d);
    if (a == 20'h00100) expRate = (d == 8'h0A);
    if (a == 20'h00101) expCnt = d[4:0];
    if (a == 20'h00600) begin
      if (d[2:0] == 3'b010) expStby = 1'b1;
      else if (d[2:0] == 3'b001) expStby = 1'b0;
    end
  endtask

  task automatic wr(logic [19:0] a, logic [7:0] d, string tag);
    doWrite(a, d);
    modelWrite(a, d);
    checkAll(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R2 in-reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R2 after-reset");

    // R1: full rate byte sweep
    for (int v = 0; v < 256; v++) wr(20'h00100, 8'(v), "R1 rate");
    // R3 R4 R5: full lane byte sweep, alternate with a valid count so blanking is seen
    for (int v = 0; v < 256; v++) begin
      wr(20'h00101, 8'(v), "R3/R4/R5 lanes");
      wr(20'h00101, 8'h04, "R4 restore");
    end
    // R4: invalid count persists across unrelated traffic
    wr(20'h00101, 8'h03, "R4 invalid");
    wr(20'h00100, 8'h0A, "R4 hold");
    wr(20'h00101, 8'h02, "R4 revalid");

    // R9: latency, old value at first edge, new at second
    wrAddr = 20'h00100; wrData = 8'h06; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
    check("R9 first edge rate", int'(rateHigh), 1);
    @(negedge clk);
    expRate = 1'b0;
    check("R9 second edge rate", int'(rateHigh), 0);

    // R6: each power code from active and from standby
    for (int v = 0; v < 8; v++) begin
      wr(20'h00600, 8'h01, "R6 prep active");
      wr(20'h00600, 8'(8'hA8 | v), "R6 code from active");
      wr(20'h00600, 8'h02, "R6 prep standby");
      wr(20'h00600, 8'(8'h50 | v), "R6 code from standby");
    end

    // R7: writes during standby
    wr(20'h00101, 8'h04, "R7 count");
    wr(20'h00600, 8'h02, "R7 enter");
    wr(20'h00101, 8'h02, "R7 count in standby");
    wr(20'h00100, 8'h0A, "R7 rate in standby");
    wr(20'h00101, 8'h01, "R7 count in standby 2");
    wr(20'h00600, 8'h01, "R7 exit");
    check("R7 restored lanes", int'(laneEn), 4'b0001);

    // R8: unmonitored addresses and idle strobes change nothing
    wr(20'h00102, 8'h04, "R8 addr 102");
    wr(20'h00000, 8'h0A, "R8 addr 0");
    wr(20'h10100, 8'h00, "R8 aliased high bit");
    wr(20'h00601, 8'h02, "R8 addr 601");
    wr(20'h000FF, 8'h02, "R8 addr FF");
    doWrite(20'h00101, 8'h00, 1'b0); checkAll("R8 valid low lane");
    doWrite(20'h00600, 8'h02, 1'b0); checkAll("R8 valid low power");
    doWrite(20'h00100, 8'h06, 1'b0); checkAll("R8 valid low rate");

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule